// File: doc/BRIEF.md
# Lock-Qualified Synchronous Reset Generator

This block turns the lock indication of a clock manager into an active-high synchronous reset for logic that runs on the generated clock. While the clock manager is held in reset or is still acquiring lock, its lock flag is low. The inverted flag is the raw reset request, and the block keeps its reset output asserted for as long as that request is present. Reset is released only after lock has stayed high for a programmed number of generated-clock cycles. If lock drops at any point, reset returns at once and the full qualification delay starts again.

The lock flag is taken as asynchronous to the generated clock and passes through a two-flop synchroniser. It then feeds a delay element of `DELAY_STAGES` cycles, either 16 or 32, followed by one output register. A parameter selects the form of the delay element. The first form is a chain of flops that all load 1 while unlocked and shift in 0 while locked. The second form is a counter that clears while unlocked and saturates at its terminal count. The counter form has no state that can wake up partly cleared, so the output cannot bounce. Every register powers up in the reset-asserted state, so the block needs no reset input of its own.

Top module: `lock_reset_gen`

## Requirements
- R1: At power-up, before any clock edge, `rst_o` is 1. It stays 1 until the release condition of R3 is met.
- R2: If `lock_i` is sampled low at a rising edge k of `clk_i`, `rst_o` is 1 after edge k+2.
- R3: Let lock be sampled high at edges k, k+1, …, k+N, where N = `DELAY_STAGES`, and low at edge k-1 (or let k be the first edge). Then `rst_o` goes to 0 after edge k+N+2 and not earlier.
- R4: A single low sample of `lock_i` restarts the whole delay. After a drop, release again needs N+1 consecutive high samples, even if the lock flag had been high for almost the full delay.
- R5: `DELAY_STAGES` may be 16 or 32, and the release latency scales with it as stated in R3.
- R6: With `USE_COUNTER` = 1, the delay is a saturating counter that clears while unlocked. The timing of `rst_o` is identical to the shift-chain form (`USE_COUNTER` = 0).
- R7: Once released, `rst_o` stays 0 for as long as `lock_i` is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Generated clock from the clock manager; clocks every register |
| lock_i | input | 1 | Lock flag from the clock manager, asynchronous, 1 = locked |
| rst_o | output | 1 | Registered active-high synchronous reset for downstream logic |

## Verification
Each output result has a fixed due time:
- A low lock sample shows on `rst_o` two edges later: one edge for the second synchroniser flop and one for the output register.
- A release shows N+2 edges after the first high sample of an unbroken run of N+1 high samples.

The bench counts consecutive high samples at every edge and delays that run length through a three-deep history. At each falling edge it compares `rst_o` against the run length from two edges back, so every check lands in the half cycle after the edge that is due to change the output.

Four instances run side by side on the same stimulus, covering both delay forms at both depths. The stimulus includes runs that end exactly one sample short of release and single-cycle lock glitches.

// File: rtl/lrg_pkg.sv
package lrg_pkg;

    // Form of the qualification delay element.
    typedef enum logic {
        DLY_SHIFT = 1'b0,
        DLY_COUNT = 1'b1
    } dly_form_e;

    // Width of a counter able to hold the value n.
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/lrg_sync.sv
module lrg_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic async_i,
    output logic sync_o
);

    typedef struct packed {
        logic [STAGES-1:0] ff;
        logic              live;
    } sync_st_t;

    sync_st_t st_d;
    sync_st_t st_q = '0;   // powers up as "not locked"

    always_comb begin
        st_d      = st_q;
        st_d.ff   = {st_q.ff[STAGES-2:0], async_i};
        st_d.live = 1'b1;
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign sync_o = st_q.ff[STAGES-1];

    // R2: the synchronised flag follows its previous stage by one edge.
    p_sync_follow_r2: assert property (@(posedge clk_i) disable iff (!st_q.live)
        1'b1 |=> (sync_o == $past(st_q.ff[STAGES-2])))
        else $error("p_sync_follow_r2");

endmodule

// File: rtl/lrg_delay.sv
module lrg_delay
    import lrg_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter dly_form_e   FORM  = DLY_SHIFT
) (
    input  logic clk_i,
    input  logic locked_i,
    output logic done_o
);

    localparam int unsigned CW = cnt_width(DEPTH);
    localparam logic [CW-1:0] TERM = CW'(DEPTH);

    generate
        if (FORM == DLY_SHIFT) begin : g_shift
            typedef struct packed {
                logic [DEPTH-1:0] chain;
                logic             live;
            } sh_st_t;

            sh_st_t st_d;
            sh_st_t st_q = '{chain: '1, live: 1'b0};

            always_comb begin
                st_d      = st_q;
                st_d.live = 1'b1;
                if (!locked_i) begin
                    st_d.chain = '1;
                end else begin
                    st_d.chain = {st_q.chain[DEPTH-2:0], 1'b0};
                end
            end

            always_ff @(posedge clk_i) begin
                st_q <= st_d;
            end

            assign done_o = (st_q.chain == '0);

            // R4: a low flag refills every stage.
            p_refill_r4: assert property (@(posedge clk_i) disable iff (!st_q.live)
                !locked_i |=> (st_q.chain == '1))
                else $error("p_refill_r4");

            // R3: done can only appear after a locked cycle.
            p_done_needs_lock_r3: assert property (@(posedge clk_i) disable iff (!st_q.live)
                $rose(done_o) |-> $past(locked_i))
                else $error("p_done_needs_lock_r3");

        end else begin : g_count
            typedef struct packed {
                logic [CW-1:0] cnt;
                logic          live;
            } ct_st_t;

            ct_st_t st_d;
            ct_st_t st_q = '{cnt: '0, live: 1'b0};

            always_comb begin
                st_d      = st_q;
                st_d.live = 1'b1;
                if (!locked_i) begin
                    st_d.cnt = '0;
                end else if (st_q.cnt != TERM) begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end

            always_ff @(posedge clk_i) begin
                st_q <= st_d;
            end

            assign done_o = (st_q.cnt == TERM);

            // R6: the counter never passes its terminal count.
            p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!st_q.live)
                st_q.cnt <= TERM)
                else $error("p_cnt_bound_r6");

            // R4: a low flag clears the count.
            p_cnt_clear_r4: assert property (@(posedge clk_i) disable iff (!st_q.live)
                !locked_i |=> (st_q.cnt == '0))
                else $error("p_cnt_clear_r4");

            // R7: the terminal count holds while lock stays.
            p_cnt_hold_r7: assert property (@(posedge clk_i) disable iff (!st_q.live)
                (done_o && locked_i) |=> done_o)
                else $error("p_cnt_hold_r7");
        end
    endgenerate

endmodule

// File: rtl/lock_reset_gen.sv
module lock_reset_gen
    import lrg_pkg::*;
#(
    parameter int unsigned DELAY_STAGES = 16,
    parameter bit          USE_COUNTER  = 1'b0,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic clk_i,
    input  logic lock_i,
    output logic rst_o
);

    localparam dly_form_e FORM = USE_COUNTER ? DLY_COUNT : DLY_SHIFT;

    logic lock_s;
    logic qual_done;

    lrg_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i   (clk_i),
        .async_i (lock_i),
        .sync_o  (lock_s)
    );

    lrg_delay #(
        .DEPTH (DELAY_STAGES),
        .FORM  (FORM)
    ) u_delay (
        .clk_i    (clk_i),
        .locked_i (lock_s),
        .done_o   (qual_done)
    );

    typedef struct packed {
        logic rst;
        logic live;
    } out_st_t;

    out_st_t st_d;
    out_st_t st_q = '{rst: 1'b1, live: 1'b0};

    always_comb begin
        st_d      = st_q;
        st_d.live = 1'b1;
        st_d.rst  = !lock_s || !qual_done;
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign rst_o = st_q.rst;

    // R1: asserted at time zero.
    initial begin
        p_powerup_r1: assert (st_q.rst == 1'b1) else $error("p_powerup_r1");
    end

    // R2: a low synchronised flag forces reset on the next edge.
    p_hold_unlocked_r2: assert property (@(posedge clk_i) disable iff (!st_q.live)
        !lock_s |=> rst_o)
        else $error("p_hold_unlocked_r2");

    // R3: release only follows a qualified, locked cycle.
    p_release_qualified_r3: assert property (@(posedge clk_i) disable iff (!st_q.live)
        $fell(rst_o) |-> ($past(qual_done) && $past(lock_s)))
        else $error("p_release_qualified_r3");

    // R7: once released, reset stays low while lock stays.
    p_stay_released_r7: assert property (@(posedge clk_i) disable iff (!st_q.live)
        (!rst_o && lock_s) |=> !rst_o)
        else $error("p_stay_released_r7");

endmodule

// File: tb/lock_reset_gen_tb.sv
`timescale 1ns/1ps
module lock_reset_gen_tb;

    localparam int N_A = 16;
    localparam int N_B = 32;

    logic clk = 1'b0;
    logic lock = 1'b0;
    logic rst_s16, rst_s32, rst_c16, rst_c32;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    lock_reset_gen #(.DELAY_STAGES(16), .USE_COUNTER(1'b0)) u_dut (
        .clk_i(clk), .lock_i(lock), .rst_o(rst_s16));
    lock_reset_gen #(.DELAY_STAGES(32), .USE_COUNTER(1'b0)) u_dut_s32 (
        .clk_i(clk), .lock_i(lock), .rst_o(rst_s32));
    lock_reset_gen #(.DELAY_STAGES(16), .USE_COUNTER(1'b1)) u_dut_c16 (
        .clk_i(clk), .lock_i(lock), .rst_o(rst_c16));
    lock_reset_gen #(.DELAY_STAGES(32), .USE_COUNTER(1'b1)) u_dut_c32 (
        .clk_i(clk), .lock_i(lock), .rst_o(rst_c32));

    // Reference: run length of high samples, delayed by two edges.
    int run0 = 0, run1 = 0, run2 = 0;
    bit exp16_prev = 1'b1, exp32_prev = 1'b1;

    always @(posedge clk) begin
        run2 <= run1;
        run1 <= run0;
        run0 <= lock ? ((run0 < 1000) ? run0 + 1 : run0) : 0;
    end

    function automatic bit exp_rst(input int run2_v, input int n);
        return !(run2_v >= n + 1);
    endfunction

    function automatic string tag_for(input bit e, input bit e_prev);
        if (!e)     return "R3/R7";
        if (!e_prev) return "R2";
        return "R4";
    endfunction

    task automatic check1(input string who, input string tag, input logic act, input bit e);
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", who, tag, act, e, $time);
        end
    endtask

    task automatic check_all();
        bit e16, e32;
        e16 = exp_rst(run2, N_A);
        e32 = exp_rst(run2, N_B);
        check1("shift16", tag_for(e16, exp16_prev), rst_s16, e16);
        check1("shift32 R5", tag_for(e32, exp32_prev), rst_s32, e32);
        check1("count16 R6", tag_for(e16, exp16_prev), rst_c16, e16);
        check1("count32 R6 R5", tag_for(e32, exp32_prev), rst_c32, e32);
        exp16_prev = e16;
        exp32_prev = e32;
    endtask

    // One cycle: check after the previous edge, then drive the next value.
    task automatic step(input logic v);
        @(negedge clk);
        check_all();
        lock = v;
    endtask

    task automatic hold(input logic v, input int n);
        for (int i = 0; i < n; i++) step(v);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        process::self().srandom(32'd7);
        #1;
        // R1: all instances asserted before any edge.
        check1("shift16", "R1", rst_s16, 1'b1);
        check1("shift32", "R1", rst_s32, 1'b1);
        check1("count16", "R1", rst_c16, 1'b1);
        check1("count32", "R1", rst_c32, 1'b1);

        hold(1'b0, 6);            // R1/R2: unlocked at start
        hold(1'b1, 40);           // R3: depth-16 releases, depth-32 releases
        hold(1'b0, 1);            // R2/R4: one-cycle drop
        hold(1'b1, N_A);          // R4: exactly one sample short for depth 16
        hold(1'b0, 1);
        hold(1'b1, N_A + 1);      // R3: exactly enough for depth 16
        hold(1'b1, 4);            // R7
        hold(1'b0, 3);
        hold(1'b1, N_B);          // one short for depth 32
        hold(1'b0, 2);
        hold(1'b1, 60);           // R7: long lock

        // Random segments.
        for (int s = 0; s < 300; s++) begin
            int len;
            logic v;
            v   = ($urandom_range(0, 3) != 0);
            len = v ? $urandom_range(1, 45) : $urandom_range(1, 4);
            hold(v, len);
        end
        hold(1'b1, 50);
        step(1'b1);
        finish_run();
    end

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
        finish_run();
    end

endmodule